// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Checker

This block watches the command pins of a single-data-rate SDRAM with two banks from the memory side. On every rising clock edge it samples clock enable, the four active-low command strobes, the bank select, the auto-precharge address bit, the three low address bits and the data mask. It turns each sample into a decoded command code, keeps a small state machine for each bank and one for the device's power and mode state, and raises a flag for any command that the current state does not allow.

It also regenerates the two data-mask strobes. The write mask follows the mask pin with no delay. The read output-disable strobe follows it two edges later. Every output is registered and shows the result of a sample right after the edge that took it. A verification environment or a memory model uses it by wiring it in parallel with the device pins and watching `illegal`.

Bank states and their transitions: BK_IDLE goes to BK_ACTIVE on a legal activate. BK_ACTIVE goes to BK_IDLE on a precharge, and goes to BK_RECOVER when an auto-precharge burst finishes or is stopped. BK_RECOVER goes back to BK_IDLE after TRP edges. Power/mode states and their transitions: PM_NORMAL goes to PM_MRS_WAIT on a legal mode register set, and PM_MRS_WAIT returns to PM_NORMAL after MRS_GAP edges. PM_NORMAL goes to PM_SELF_REF on a legal self-refresh entry. PM_NORMAL goes to PM_PRE_PD or PM_ACT_PD when clock enable falls. Each of the last three returns to PM_NORMAL when clock enable rises again.

Top module: `sdram_cmd_checker`

## Requirements
- R1: `cmd_code` shows the decoded sample one edge later. Strobes {cs_n,ras_n,cas_n,we_n} decode as follows: 0000 mode set = 1; 0001 refresh = 2; 0011 activate = 4; 0101 read = 5, or 6 with a10 high; 0100 write = 7, or 8 with a10 high; 0110 burst stop = 9; 0010 precharge = 10, or 11 with a10 high; 0111 or cs_n high = 0 (no operation). When clock enable was high and is now low, refresh strobes give 3 (self-refresh entry) and anything else gives 12 (power-down entry). When clock enable was low and is now high the code is 13 (exit). When it stays low the code is 0. After reset `cmd_code`, `illegal`, both bank states, `pwr_state`, `wr_mask` and `rd_hiz` are all 0.
- R2: Bank state codes are 0 idle, 1 active and 2 recovering. The bank select pin `ba` picks bank A when low and bank B when high. A legal activate moves an idle bank to active. An activate to a bank that is not idle is illegal.
- R3: A read or write to a bank that is not active is illegal.
- R4: A precharge with a10 low returns the bank selected by `ba` to idle. With a10 high it ignores `ba` and returns every active bank to idle. A precharge of an idle bank is legal and has no effect.
- R5: Mode set, auto refresh and self-refresh entry are illegal unless both banks are idle and no burst is running. A mode set with a_lo above 3 is illegal. A legal mode set loads a burst length of 1, 2, 4 or 8 from a_lo codes 0 to 3.
- R6: After a legal mode set, `pwr_state` is 1 for MRS_GAP edges. Any command other than no-operation sampled in that window is illegal.
- R7: A read or write with a10 high starts an auto-precharge burst of the loaded length, counted from the command edge. While that burst runs, every read or write is illegal. After the burst's last edge the bank shows 2. TRP edges later it shows 0, and only then is an activate to it legal.
- R8: Burst stop is always legal and ends the running burst at once. If the burst was an auto-precharge burst, its bank enters recovery from that edge.
- R9: `pwr_state` codes are 0 normal, 1 mode-set wait, 2 self refresh, 3 precharge power-down and 4 active power-down. A legal self-refresh entry gives 2, and a rise of clock enable returns it to 0. An entry that breaks R5 is illegal and leaves `pwr_state` at 0.
- R10: When clock enable falls on a sample that is not a self-refresh entry, `pwr_state` becomes 3 if both banks are idle and 4 otherwise. A rise of clock enable returns it to 0.
- R11: `wr_mask` equals `dqm` sampled on the same edge. `rd_hiz` equals `dqm` sampled two edges earlier.
- R12: `illegal` is high only for the edge after the offending sample. An illegal command changes neither bank state nor power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select (0 = A, 1 = B) |
| a10 | input | 1 | Auto-precharge / all-bank address bit |
| a_lo | input | 3 | Address bits 2..0, burst-length code at mode set |
| dqm | input | 1 | Data mask pin |
| cmd_code | output | 4 | Decoded command of the last sample |
| bank_a_st | output | 2 | Bank A state |
| bank_b_st | output | 2 | Bank B state |
| pwr_state | output | 3 | Power / mode state |
| illegal | output | 1 | Last sample was an illegal command |
| wr_mask | output | 1 | Write data mask, latency 0 |
| rd_hiz | output | 1 | Read output disable, latency 2 |

## Verification
The properties assume that clock enable only changes while the checker is in normal state or one of the low-power states, never inside the mode-set wait window. They also assume that no precharge or activate arrives while a bank has its recovery countdown running in a low-power state. The stimulus keeps to this. Every clock-enable drop is issued with no burst in flight and outside the mode-set window, and exits always follow entries. Illegal commands are issued on purpose so that the properties on mode-set and self-refresh entry can be checked against states the checker refused to enter.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_REF  = 4'd2,
        CMD_SREF = 4'd3,
        CMD_ACT  = 4'd4,
        CMD_RD   = 4'd5,
        CMD_RDA  = 4'd6,
        CMD_WR   = 4'd7,
        CMD_WRA  = 4'd8,
        CMD_BST  = 4'd9,
        CMD_PRE  = 4'd10,
        CMD_PALL = 4'd11,
        CMD_PDN  = 4'd12,
        CMD_EXIT = 4'd13
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_ACTIVE  = 2'd1,
        BK_RECOVER = 2'd2
    } bank_st_e;

    typedef enum logic [2:0] {
        PM_NORMAL   = 3'd0,
        PM_MRS_WAIT = 3'd1,
        PM_SELF_REF = 3'd2,
        PM_PRE_PD   = 3'd3,
        PM_ACT_PD   = 3'd4
    } pmode_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cke_prev,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev) begin
            cmd = cke ? CMD_EXIT : CMD_NOP;
        end else if (!cke) begin
            cmd = (!cs_n && !ras_n && !cas_n && we_n) ? CMD_SREF : CMD_PDN;
        end else if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
                3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = a10 ? CMD_PALL : CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_chk_pkg::*;
#(
    parameter int TRP = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     do_act,
    input  logic     do_pre,
    input  logic     do_rec,
    output bank_st_e state
);

    localparam int CW = $clog2(TRP + 1);

    bank_st_e        st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            BK_IDLE: begin
                if (do_act) st_d = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (do_rec) begin
                    st_d  = BK_RECOVER;
                    cnt_d = CW'(TRP);
                end else if (do_pre) begin
                    st_d = BK_IDLE;
                end
            end
            BK_RECOVER: begin
                if (cnt_q <= CW'(1)) begin
                    st_d  = BK_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: st_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/sdram_chk_ctrl.sv
module sdram_chk_ctrl
    import sdram_chk_pkg::*;
#(
    parameter int MRS_GAP = 2,
    parameter int MAX_BL  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_e       cmd,
    input  logic       ba,
    input  logic [2:0] mode_bits,
    input  bank_st_e   st_a,
    input  bank_st_e   st_b,
    output logic       ill,
    output logic [1:0] act_req,
    output logic [1:0] pre_req,
    output logic [1:0] rec_req,
    output pmode_e     pmode
);

    localparam int GW = $clog2(MRS_GAP + 1);
    localparam int BW = $clog2(MAX_BL + 1);

    pmode_e          pm_q, pm_d;
    logic [GW-1:0]   gap_q, gap_d;
    logic [BW-1:0]   left_q, left_d;
    logic [BW-1:0]   blen_q, blen_d;
    logic            ap_q, ap_d;
    logic            bb_q, bb_d;

    bank_st_e        tgt_st;
    logic            both_idle, run, ap_run;

    assign tgt_st    = ba ? st_b : st_a;
    assign both_idle = (st_a == BK_IDLE) && (st_b == BK_IDLE);
    assign run       = (left_q != '0);
    assign ap_run    = run && ap_q;

    always_comb begin
        ill     = 1'b0;
        act_req = '0;
        pre_req = '0;
        rec_req = '0;
        pm_d    = pm_q;
        gap_d   = gap_q;
        left_d  = left_q;
        blen_d  = blen_q;
        ap_d    = ap_q;
        bb_d    = bb_q;

        if ((pm_q == PM_NORMAL || pm_q == PM_MRS_WAIT) && run) begin
            left_d = left_q - BW'(1);
            if (left_q == BW'(1) && ap_q) rec_req[bb_q] = 1'b1;
        end

        unique case (pm_q)
            PM_MRS_WAIT: begin
                ill = (cmd != CMD_NOP);
                if (gap_q <= GW'(1)) pm_d = PM_NORMAL;
                else                 gap_d = gap_q - GW'(1);
            end
            PM_SELF_REF, PM_PRE_PD, PM_ACT_PD: begin
                if (cmd == CMD_EXIT) pm_d = PM_NORMAL;
            end
            PM_NORMAL: begin
                unique case (cmd)
                    CMD_MRS: begin
                        if (!both_idle || run || mode_bits[2]) begin
                            ill = 1'b1;
                        end else begin
                            pm_d   = PM_MRS_WAIT;
                            gap_d  = GW'(MRS_GAP);
                            blen_d = BW'(1) << mode_bits[1:0];
                        end
                    end
                    CMD_REF: ill = !both_idle || run;
                    CMD_SREF: begin
                        if (!both_idle || run) ill = 1'b1;
                        else                   pm_d = PM_SELF_REF;
                    end
                    CMD_PDN: pm_d = both_idle ? PM_PRE_PD : PM_ACT_PD;
                    CMD_ACT: begin
                        if (tgt_st != BK_IDLE) ill = 1'b1;
                        else                   act_req[ba] = 1'b1;
                    end
                    CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
                        if (tgt_st != BK_ACTIVE || ap_run) begin
                            ill = 1'b1;
                        end else begin
                            ap_d = (cmd == CMD_RDA) || (cmd == CMD_WRA);
                            bb_d = ba;
                            if (blen_q == BW'(1)) begin
                                left_d = '0;
                                if (ap_d) rec_req[ba] = 1'b1;
                            end else begin
                                left_d = blen_q - BW'(1);
                            end
                        end
                    end
                    CMD_BST: begin
                        left_d = '0;
                        if (ap_run) rec_req[bb_q] = 1'b1;
                    end
                    CMD_PRE: begin
                        if (ap_run && bb_q == ba) begin
                            ill = 1'b1;
                        end else begin
                            if (tgt_st == BK_ACTIVE) pre_req[ba] = 1'b1;
                            if (run && bb_q == ba)   left_d = '0;
                        end
                    end
                    CMD_PALL: begin
                        if (ap_run) begin
                            ill = 1'b1;
                        end else begin
                            pre_req[0] = (st_a == BK_ACTIVE);
                            pre_req[1] = (st_b == BK_ACTIVE);
                            left_d     = '0;
                        end
                    end
                    default: ;
                endcase
            end
            default: pm_d = PM_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q   <= PM_NORMAL;
            gap_q  <= '0;
            left_q <= '0;
            blen_q <= BW'(1);
            ap_q   <= 1'b0;
            bb_q   <= 1'b0;
        end else begin
            pm_q   <= pm_d;
            gap_q  <= gap_d;
            left_q <= left_d;
            blen_q <= blen_d;
            ap_q   <= ap_d;
            bb_q   <= bb_d;
        end
    end

    assign pmode = pm_q;

endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm,
    output logic wr_mask,
    output logic rd_hiz
);

    logic [RD_LAT:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[RD_LAT-1:0], dqm};
    end

    assign wr_mask = sh_q[0];
    assign rd_hiz  = sh_q[RD_LAT];

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int TRP        = 3,
    parameter int MRS_GAP    = 2,
    parameter int MAX_BL     = 8,
    parameter int RD_DQM_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       ba,
    input  logic       a10,
    input  logic [2:0] a_lo,
    input  logic       dqm,
    output logic [3:0] cmd_code,
    output logic [1:0] bank_a_st,
    output logic [1:0] bank_b_st,
    output logic [2:0] pwr_state,
    output logic       illegal,
    output logic       wr_mask,
    output logic       rd_hiz
);

    localparam int NBANK = 2;

    logic           cke_prev_q;
    cmd_e           cmd, cmd_q;
    logic           ill, ill_q;
    logic [1:0]     act_req, pre_req, rec_req;
    bank_st_e       bst [NBANK];
    pmode_e         pmode;

    sdram_cmd_decode u_dec (
        .cke_prev (cke_prev_q),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (a10),
        .cmd      (cmd)
    );

    sdram_chk_ctrl #(
        .MRS_GAP (MRS_GAP),
        .MAX_BL  (MAX_BL)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .ba        (ba),
        .mode_bits (a_lo),
        .st_a      (bst[0]),
        .st_b      (bst[1]),
        .ill       (ill),
        .act_req   (act_req),
        .pre_req   (pre_req),
        .rec_req   (rec_req),
        .pmode     (pmode)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdram_bank_fsm #(.TRP(TRP)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .do_act (act_req[g]),
            .do_pre (pre_req[g]),
            .do_rec (rec_req[g]),
            .state  (bst[g])
        );
    end

    sdram_dqm_pipe #(.RD_LAT(RD_DQM_LAT)) u_dqm (
        .clk     (clk),
        .rst_n   (rst_n),
        .dqm     (dqm),
        .wr_mask (wr_mask),
        .rd_hiz  (rd_hiz)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_prev_q <= 1'b1;
            cmd_q      <= CMD_NOP;
            ill_q      <= 1'b0;
        end else begin
            cke_prev_q <= cke;
            cmd_q      <= cmd;
            ill_q      <= ill;
        end
    end

    assign cmd_code  = cmd_q;
    assign illegal   = ill_q;
    assign bank_a_st = bst[0];
    assign bank_b_st = bst[1];
    assign pwr_state = pmode;

endmodule

// File: rtl/sdram_chk_sva.sv
module sdram_chk_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bank_a_st,
    input logic [1:0] bank_b_st,
    input logic [2:0] pwr_state,
    input logic       wr_mask,
    input logic       rd_hiz
);

    a_r5_mrs_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_state == 3'd1) |-> ($past(bank_a_st) == 2'd0 && $past(bank_b_st) == 2'd0));

    a_r6_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_state == 3'd1) |=> (pwr_state == 3'd1));

    a_r7_recover_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_a_st == 2'd2) |=> (bank_a_st != 2'd1));

    a_r9_sref_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_state == 3'd2) |-> ($past(bank_a_st) == 2'd0 && $past(bank_b_st) == 2'd0));

    a_r10_pre_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd3 && $past(pwr_state) == 3'd0)
            |-> ($past(bank_a_st) == 2'd0 && $past(bank_b_st) == 2'd0));

    a_r10_act_pd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd4 && $past(pwr_state) == 3'd0)
            |-> ($past(bank_a_st) != 2'd0 || $past(bank_b_st) != 2'd0));

    a_r11_read_mask_lag: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hiz == $past(wr_mask, 2));

    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r2_state_code: assert (bank_a_st != 2'd3 && bank_b_st != 2'd3);
        end
    end

endmodule

bind sdram_cmd_checker sdram_chk_sva u_sva (.*);

// File: tb/test_sdram_cmd_checker.sv
module test_sdram_cmd_checker;

    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_ACT = 4'b0011,
                           C_RD  = 4'b0101, C_WR  = 4'b0100, C_BST = 4'b0110,
                           C_PRE = 4'b0010, C_NOP = 4'b0111, C_DES = 4'b1111;

    typedef struct {
        logic       ill;
        logic [3:0] code;
        logic [1:0] sa;
        logic [1:0] sb;
        logic [2:0] pm;
        logic       wm;
        logic       rh;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       ba = 1'b0, a10 = 1'b0;
    logic [2:0] a_lo = 3'd0;
    logic       dqm = 1'b0;
    logic [3:0] cmd_code;
    logic [1:0] bank_a_st, bank_b_st;
    logic [2:0] pwr_state;
    logic       illegal, wr_mask, rd_hiz;

    int   n_chk = 0;
    int   n_fail = 0;
    logic dq_h1 = 1'b0, dq_h2 = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_checker i_sdram_cmd_checker (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .a_lo(a_lo), .dqm(dqm),
        .cmd_code(cmd_code), .bank_a_st(bank_a_st), .bank_b_st(bank_b_st),
        .pwr_state(pwr_state), .illegal(illegal), .wr_mask(wr_mask), .rd_hiz(rd_hiz)
    );

    task automatic cyc(input logic cke_v, input logic [3:0] c, input logic ba_v,
                       input logic a10_v, input logic [2:0] m, input logic dq,
                       input logic ill, input logic [3:0] code, input logic [1:0] sa,
                       input logic [1:0] sb, input logic [2:0] pm, input string req);
        exp_t e;
        @(negedge clk);
        cke = cke_v;
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = ba_v; a10 = a10_v; a_lo = m; dqm = dq;
        e.ill = ill; e.code = code; e.sa = sa; e.sb = sb; e.pm = pm;
        e.wm = dq; e.rh = dq_h2; e.req = req;
        dq_h2 = dq_h1; dq_h1 = dq;
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_chk++;
                if (illegal !== e.ill || cmd_code !== e.code || bank_a_st !== e.sa ||
                    bank_b_st !== e.sb || pwr_state !== e.pm || wr_mask !== e.wm ||
                    rd_hiz !== e.rh) begin
                    n_fail++;
                    $display("FAIL %s: got ill=%0b code=%0d a=%0d b=%0d pm=%0d wm=%0b rh=%0b, exp ill=%0b code=%0d a=%0d b=%0d pm=%0d wm=%0b rh=%0b",
                             e.req, illegal, cmd_code, bank_a_st, bank_b_st, pwr_state,
                             wr_mask, rd_hiz, e.ill, e.code, e.sa, e.sb, e.pm, e.wm, e.rh);
                end
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;  // R1 reset state
        if ({cmd_code, illegal, bank_a_st, bank_b_st, pwr_state, wr_mask, rd_hiz} !== '0) begin
            n_fail++;
            $display("FAIL R1: got code=%0d ill=%0b a=%0d b=%0d pm=%0d, exp all zero",
                     cmd_code, illegal, bank_a_st, bank_b_st, pwr_state);
        end
        //  cke  cmd    ba a10 mode dq   ill code a  b  pm  req
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0,  0, 0, 0, 0, "R1");
        cyc(1, C_RD,  0, 0, 3'd0, 0,  1,  5, 0, 0, 0, "R3");
        cyc(1, C_MRS, 0, 0, 3'd2, 0,  0,  1, 0, 0, 1, "R5 R12");
        cyc(1, C_ACT, 0, 0, 3'd0, 0,  1,  4, 0, 0, 1, "R6");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0,  0, 0, 0, 0, "R6");
        cyc(1, C_ACT, 0, 0, 3'd0, 0,  0,  4, 1, 0, 0, "R2");
        cyc(1, C_ACT, 0, 0, 3'd0, 0,  1,  4, 1, 0, 0, "R2");
        cyc(1, C_MRS, 0, 0, 3'd0, 0,  1,  1, 1, 0, 0, "R5 R12");
        cyc(1, C_REF, 0, 0, 3'd0, 0,  1,  2, 1, 0, 0, "R5");
        cyc(1, C_ACT, 1, 0, 3'd0, 0,  0,  4, 1, 1, 0, "R2");
        cyc(1, C_WR,  1, 0, 3'd0, 0,  0,  7, 1, 1, 0, "R3");
        cyc(1, C_RD,  0, 1, 3'd0, 0,  0,  6, 1, 1, 0, "R7");
        cyc(1, C_WR,  1, 0, 3'd0, 0,  1,  7, 1, 1, 0, "R7");
        cyc(1, C_NOP, 0, 0, 3'd0, 1,  0,  0, 1, 1, 0, "R11");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0,  0, 2, 1, 0, "R7");
        cyc(1, C_ACT, 0, 0, 3'd0, 0,  1,  4, 2, 1, 0, "R7");
        cyc(1, C_NOP, 0, 0, 3'd0, 1,  0,  0, 2, 1, 0, "R11");
        cyc(1, C_NOP, 0, 0, 3'd0, 1,  0,  0, 0, 1, 0, "R7");
        cyc(1, C_ACT, 0, 0, 3'd0, 0,  0,  4, 1, 1, 0, "R2");
        cyc(1, C_RD,  0, 1, 3'd0, 0,  0,  6, 1, 1, 0, "R7");
        cyc(1, C_BST, 0, 0, 3'd0, 0,  0,  9, 2, 1, 0, "R8");
        cyc(1, C_RD,  1, 0, 3'd0, 0,  0,  5, 2, 1, 0, "R8");
        cyc(1, C_PRE, 0, 1, 3'd0, 0,  0, 11, 2, 0, 0, "R4");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0,  0, 0, 0, 0, "R7");
        cyc(1, C_ACT, 1, 0, 3'd0, 0,  0,  4, 0, 1, 0, "R2");
        cyc(1, C_PRE, 0, 0, 3'd0, 0,  0, 10, 0, 1, 0, "R4");
        cyc(1, C_PRE, 1, 0, 3'd0, 0,  0, 10, 0, 0, 0, "R4");
        cyc(1, C_REF, 0, 0, 3'd0, 0,  0,  2, 0, 0, 0, "R5");
        cyc(0, C_NOP, 0, 0, 3'd0, 0,  0, 12, 0, 0, 3, "R10");
        cyc(0, C_NOP, 0, 0, 3'd0, 0,  0,  0, 0, 0, 3, "R10");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0, 13, 0, 0, 0, "R10");
        cyc(1, C_ACT, 0, 0, 3'd0, 0,  0,  4, 1, 0, 0, "R2");
        cyc(0, C_NOP, 0, 0, 3'd0, 0,  0, 12, 1, 0, 4, "R10");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0, 13, 1, 0, 0, "R10");
        cyc(0, C_REF, 0, 0, 3'd0, 0,  1,  3, 1, 0, 0, "R9 R12");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0, 13, 1, 0, 0, "R9");
        cyc(1, C_PRE, 0, 0, 3'd0, 0,  0, 10, 0, 0, 0, "R4");
        cyc(0, C_REF, 0, 0, 3'd0, 0,  0,  3, 0, 0, 2, "R9");
        cyc(0, C_NOP, 0, 0, 3'd0, 0,  0,  0, 0, 0, 2, "R9");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0, 13, 0, 0, 0, "R9");
        cyc(1, C_DES, 0, 0, 3'd0, 0,  0,  0, 0, 0, 0, "R1");
        cyc(1, C_MRS, 0, 0, 3'd7, 0,  1,  1, 0, 0, 0, "R5");
        cyc(1, C_MRS, 0, 0, 3'd0, 0,  0,  1, 0, 0, 1, "R5");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0,  0, 0, 0, 1, "R6");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0,  0, 0, 0, 0, "R6");
        cyc(1, C_ACT, 0, 0, 3'd0, 0,  0,  4, 1, 0, 0, "R2");
        cyc(1, C_WR,  0, 1, 3'd0, 0,  0,  8, 2, 0, 0, "R7");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0,  0, 2, 0, 0, "R7");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0,  0, 2, 0, 0, "R7");
        cyc(1, C_NOP, 0, 0, 3'd0, 0,  0,  0, 0, 0, 0, "R7");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule